// File: doc/BRIEF.md
# External Edge Event Counter

A 24-bit event counter that runs on the system clock and counts edges seen on an asynchronous external input. The input is brought into the clock domain by a two-stage synchronizer. Edges are then found by comparing successive synchronized samples. Software picks the edge polarity and the count direction. It also sets a 24-bit load value, a match value and an enable bit, all through a small register port.

The count is a 16-bit low part with an 8-bit prescale extension above it. When the count reaches the match value, a sticky interrupt flag is set. What follows depends on the direction:

- **Down-counting:** the counter reloads from the load and prescale registers, clears its own enable, and ignores edges until software enables it again.
- **Up-counting:** the counter returns to zero and keeps running.

The flag drives the interrupt output through a mask bit. Software clears the flag by writing a one.

Every edge is counted only if each input level lasts at least two system clocks. This means the input frequency must stay below a quarter of the clock rate.

Register map (the address is `addr_i`, data is 16 bits):

| Address | Name | Contents |
|---|---|---|
| 0 | control | bit0 enable, bit1 direction (1 up, 0 down), bits3:2 edge select, bit4 interrupt mask |
| 1 | load | low 16 bits of the load value |
| 2 | prescale | bits 7:0, the upper 8 bits of the load value |
| 3 | match | match value |
| 4 | count low | count bits 15:0 |
| 5 | count high | count bits 23:16 in bits 7:0 |
| 6 | flag | read: bit0 is the flag; write: bit0 = 1 clears it |
| 7 | unused | reads zero |

Top module: `edge_event_counter`

## Requirements
- R1: With enable set, each qualifying edge changes the 24-bit count by exactly one: +1 when control bit1 is 1, -1 when it is 0, both modulo 2^24. The new count is visible after the third rising clock edge that follows the input change.
- R2: Control bits 3:2 select the qualifying edge: 00 rising, 01 falling, 10 or 11 both edges.
- R3: The count reads as {count high[7:0], count low[15:0]}. The reload value is {prescale[7:0], load[15:0]}. The match test compares the whole 24-bit next count against the match register zero-extended to 24 bits.
- R4: When a down-count step would produce the match value, the count is instead loaded with the reload value, control bit0 clears, and the flag sets. A software write to control in the same cycle wins over that clear.
- R5: While control bit0 is 0, input edges have no effect and the count holds.
- R6: When an up-count step would produce the match value, the count becomes zero, the flag sets, and enable stays set.
- R7: The flag stays set until a write to address 6 with bit0 = 1. A match in the same cycle keeps it set.
- R8: `irq_o` is high exactly when the flag and control bit4 are both 1.
- R9: Writes to addresses 4 and 5 load the count while enable is 0, and are ignored while enable is 1.
- R10: After reset all registers, the count and the flag are zero and `irq_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| evt_i | input | 1 | Asynchronous external event input |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register address for read and write |
| wdata_i | input | 16 | Register write data |
| rdata_o | output | 16 | Read data for `addr_i` (combinational) |
| irq_o | output | 1 | Masked match interrupt |

## Verification
- **Wrong count or direction:** shows on the count-low and count-high registers three clocks after the input change that caused it. The reference model compares every cycle, so the error is caught at once.
- **Wrong stop state after a down match:** a stale enable shows in bit0 of the control read-back in the cycle after the match. If it stays unnoticed, the next ignored edge moves the count.
- **Flag or mask faults:** these reach `irq_o` in the cycle after the match or the clear write.

// File: rtl/eec_pkg.sv
package eec_pkg;
  localparam int ADDR_W = 3;
  localparam logic [ADDR_W-1:0] A_CTRL   = 3'd0;
  localparam logic [ADDR_W-1:0] A_LOAD   = 3'd1;
  localparam logic [ADDR_W-1:0] A_PRE    = 3'd2;
  localparam logic [ADDR_W-1:0] A_MATCH  = 3'd3;
  localparam logic [ADDR_W-1:0] A_CNT_LO = 3'd4;
  localparam logic [ADDR_W-1:0] A_CNT_HI = 3'd5;
  localparam logic [ADDR_W-1:0] A_FLAG   = 3'd6;

  typedef enum logic [1:0] {
    EDGE_RISE = 2'b00,
    EDGE_FALL = 2'b01,
    EDGE_BOTH = 2'b10,
    EDGE_ANY  = 2'b11
  } edge_sel_e;
endpackage

// File: rtl/eec_sync_edge.sv
module eec_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       async_i,
  input  logic [1:0] sel_i,
  output logic       pulse_o
);
  // STAGES synchronizer flops plus one history flop
  logic [STAGES:0] pipe_q;
  logic cur, old;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pipe_q <= '0;
    else         pipe_q <= {pipe_q[STAGES-1:0], async_i};
  end

  assign cur = pipe_q[STAGES-1];
  assign old = pipe_q[STAGES];

  always_comb begin
    unique case (sel_i)
      2'b00:   pulse_o = cur & ~old;
      2'b01:   pulse_o = ~cur & old;
      default: pulse_o = cur ^ old;
    endcase
  end
endmodule

// File: rtl/eec_counter.sv
module eec_counter #(
  parameter int CNT_W = 16,
  parameter int PRE_W = 8,
  localparam int FULL_W = CNT_W + PRE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              up_i,
  input  logic              step_i,
  input  logic [FULL_W-1:0] reload_i,
  input  logic [FULL_W-1:0] match_i,
  input  logic              wr_lo_i,
  input  logic              wr_hi_i,
  input  logic [CNT_W-1:0]  wdata_i,
  output logic [FULL_W-1:0] cnt_o,
  output logic              hit_o,
  output logic              stop_o
);
  logic [FULL_W-1:0] cnt_q, nxt;

  assign nxt    = up_i ? cnt_q + FULL_W'(1) : cnt_q - FULL_W'(1);
  assign hit_o  = en_i && step_i && (nxt == match_i);
  assign stop_o = hit_o && !up_i;
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (en_i) begin
      if (step_i) begin
        if (hit_o) cnt_q <= up_i ? '0 : reload_i;
        else       cnt_q <= nxt;
      end
    end else begin
      if (wr_lo_i) cnt_q[CNT_W-1:0]      <= wdata_i;
      if (wr_hi_i) cnt_q[FULL_W-1:CNT_W] <= wdata_i[PRE_W-1:0];
    end
  end
endmodule

// File: rtl/edge_event_counter.sv
module edge_event_counter
  import eec_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int PRE_W       = 8,
  parameter int SYNC_STAGES = 2,
  localparam int FULL_W     = CNT_W + PRE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              evt_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [CNT_W-1:0]  wdata_i,
  output logic [CNT_W-1:0]  rdata_o,
  output logic              irq_o
);
  logic             en_q, up_q, mask_q, flag_q;
  logic [1:0]       edge_q;
  logic [CNT_W-1:0] load_q, match_q;
  logic [PRE_W-1:0] pre_q;
  logic [FULL_W-1:0] cnt_full;
  logic step, hit, stop;
  logic wr_ctrl, wr_flag;

  assign wr_ctrl = wr_en_i && (addr_i == A_CTRL);
  assign wr_flag = wr_en_i && (addr_i == A_FLAG);

  eec_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i (evt_i),
    .sel_i   (edge_q),
    .pulse_o (step)
  );

  eec_counter #(.CNT_W(CNT_W), .PRE_W(PRE_W)) u_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (en_q),
    .up_i     (up_q),
    .step_i   (step),
    .reload_i ({pre_q, load_q}),
    .match_i  ({{PRE_W{1'b0}}, match_q}),
    .wr_lo_i  (wr_en_i && (addr_i == A_CNT_LO)),
    .wr_hi_i  (wr_en_i && (addr_i == A_CNT_HI)),
    .wdata_i  (wdata_i),
    .cnt_o    (cnt_full),
    .hit_o    (hit),
    .stop_o   (stop)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q    <= 1'b0;
      up_q    <= 1'b0;
      edge_q  <= EDGE_RISE;
      mask_q  <= 1'b0;
      load_q  <= '0;
      pre_q   <= '0;
      match_q <= '0;
    end else begin
      if (wr_ctrl) begin
        en_q   <= wdata_i[0];
        up_q   <= wdata_i[1];
        edge_q <= wdata_i[3:2];
        mask_q <= wdata_i[4];
      end else if (stop) begin
        en_q <= 1'b0;  // self-disable after down-count match
      end
      if (wr_en_i && addr_i == A_LOAD)  load_q  <= wdata_i;
      if (wr_en_i && addr_i == A_PRE)   pre_q   <= wdata_i[PRE_W-1:0];
      if (wr_en_i && addr_i == A_MATCH) match_q <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     flag_q <= 1'b0;
    else if (hit)                    flag_q <= 1'b1;
    else if (wr_flag && wdata_i[0])  flag_q <= 1'b0;
  end

  assign irq_o = flag_q & mask_q;

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      A_CTRL:   rdata_o[4:0]       = {mask_q, edge_q, up_q, en_q};
      A_LOAD:   rdata_o            = load_q;
      A_PRE:    rdata_o[PRE_W-1:0] = pre_q;
      A_MATCH:  rdata_o            = match_q;
      A_CNT_LO: rdata_o            = cnt_full[CNT_W-1:0];
      A_CNT_HI: rdata_o[PRE_W-1:0] = cnt_full[FULL_W-1:CNT_W];
      A_FLAG:   rdata_o[0]         = flag_q;
      default:  rdata_o            = '0;
    endcase
  end
endmodule

// File: rtl/eec_checker.sv
module eec_checker
  import eec_pkg::*;
#(
  parameter int FULL_W = 24,
  parameter int CNT_W  = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [CNT_W-1:0]  wdata_i,
  input logic              irq_o,
  input logic              en,
  input logic              up,
  input logic              mask,
  input logic              flag,
  input logic              step,
  input logic              hit,
  input logic [FULL_W-1:0] cnt
);
  logic wr_cnt, wr_ctrl, clr;
  assign wr_cnt  = wr_en_i && (addr_i == A_CNT_LO || addr_i == A_CNT_HI);
  assign wr_ctrl = wr_en_i && (addr_i == A_CTRL);
  assign clr     = wr_en_i && (addr_i == A_FLAG) && wdata_i[0];

  p_up_step_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en && up && step && !hit) |=> cnt == $past(cnt) + FULL_W'(1));
  p_down_step_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en && !up && step && !hit) |=> cnt == $past(cnt) - FULL_W'(1));
  p_down_stop_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit && !up && !wr_ctrl) |=> !en);
  p_idle_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en && !wr_cnt) |=> $stable(cnt));
  p_up_zero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit && up) |=> cnt == '0);
  p_flag_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag && !clr) |=> flag);
  p_irq_on_hit_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit && mask && !wr_ctrl) |=> irq_o);
  p_busy_write_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en && !step && wr_cnt) |=> $stable(cnt));
endmodule

bind edge_event_counter eec_checker #(.FULL_W(FULL_W), .CNT_W(CNT_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .wr_en_i (wr_en_i),
  .addr_i  (addr_i),
  .wdata_i (wdata_i),
  .irq_o   (irq_o),
  .en      (en_q),
  .up      (up_q),
  .mask    (mask_q),
  .flag    (flag_q),
  .step    (step),
  .hit     (hit),
  .cnt     (cnt_full)
);

// File: tb/tb_edge_event_counter.sv
`timescale 1ns/1ps
module tb_edge_event_counter;
  logic        clk = 0, rst_n = 0, evt = 0, wr = 0;
  logic [2:0]  addr = 0;
  logic [15:0] wdata = 0, rdata;
  logic        irq;
  int tests = 0, fails = 0, cycles = 0;
  string cur_req = "R10";

  edge_event_counter dut (
    .clk_i(clk), .rst_ni(rst_n), .evt_i(evt), .wr_en_i(wr),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq));

  always #2.5 clk = ~clk;

  // behavioural reference model
  bit m_en, m_up, m_mask, m_flag;
  bit [1:0] m_edge;
  int unsigned m_load, m_pre, m_match, m_cnt;
  bit hist[$];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_en = 0; m_up = 0; m_mask = 0; m_flag = 0; m_edge = 0;
      m_load = 0; m_pre = 0; m_match = 0; m_cnt = 0;
      hist = '{0, 0, 0};
    end else begin
      bit nw, od, q, hit, stop;
      int unsigned nxt, ncnt;
      nw = hist[hist.size()-1 - 1 + 1 - 1];
      od = hist[hist.size()-3 + 1 - 1];
      nw = hist[1]; od = hist[0];
      case (m_edge)
        2'b00: q = nw && !od;
        2'b01: q = !nw && od;
        default: q = nw != od;
      endcase
      hit = 0; stop = 0; ncnt = m_cnt;
      if (m_en) begin
        if (q) begin
          nxt = m_up ? (m_cnt + 1) & 32'hFFFFFF : (m_cnt - 1) & 32'hFFFFFF;
          if (nxt == m_match) begin
            hit = 1;
            ncnt = m_up ? 0 : (m_pre << 16) | m_load;
            stop = !m_up;
          end else ncnt = nxt;
        end
      end else if (wr && addr == 4) ncnt = (m_cnt & 32'hFF0000) | wdata;
      else if (wr && addr == 5) ncnt = (m_cnt & 32'h00FFFF) | ((wdata & 32'hFF) << 16);
      m_cnt = ncnt;
      if (hit) m_flag = 1;
      else if (wr && addr == 6 && wdata[0]) m_flag = 0;
      if (wr && addr == 0) begin
        m_en = wdata[0]; m_up = wdata[1]; m_edge = wdata[3:2]; m_mask = wdata[4];
      end else if (stop) m_en = 0;
      if (wr && addr == 1) m_load = wdata;
      if (wr && addr == 2) m_pre = wdata & 32'hFF;
      if (wr && addr == 3) m_match = wdata;
      void'(hist.pop_front());
      hist.push_back(evt);
    end
  end

  function automatic int unsigned exp_read(input logic [2:0] a);
    case (a)
      0: return {m_mask, m_edge, m_up, m_en};
      1: return m_load;
      2: return m_pre;
      3: return m_match;
      4: return m_cnt & 32'hFFFF;
      5: return (m_cnt >> 16) & 32'hFF;
      6: return m_flag;
      default: return 0;
    endcase
  endfunction

  // per-cycle comparison against the model
  always @(negedge clk) if (rst_n) begin
    cycles++;
    tests++;
    if (rdata !== 16'(exp_read(addr)) || irq !== (m_flag && m_mask)) begin
      fails++;
      $display("FAIL %s cycle model: addr=%0d rdata=%h exp=%h irq=%b exp=%b",
               cur_req, addr, rdata, 16'(exp_read(addr)), irq, m_flag && m_mask);
    end
  end

  task automatic wreg(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk); #1; wr = 1; addr = a; wdata = d;
    @(negedge clk); #1; wr = 0;
  endtask

  task automatic pulse();
    @(negedge clk); #1; evt = 1;
    repeat (3) @(negedge clk);
    #1; evt = 0;
    repeat (3) @(negedge clk);
  endtask

  task automatic chk(input logic [2:0] a, input logic [15:0] e, input string req);
    repeat (4) @(negedge clk);
    #1; addr = a; #1;
    tests++;
    if (rdata !== e) begin
      fails++;
      $display("FAIL %s addr %0d: actual=%h expected=%h", req, a, rdata, e);
    end
  endtask

  task automatic chk_irq(input logic e, input string req);
    #1; tests++;
    if (irq !== e) begin
      fails++;
      $display("FAIL %s irq: actual=%b expected=%b", req, irq, e);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1; rst_n = 1;
    // R10 reset state
    for (int a = 0; a < 8; a++) chk(3'(a), 16'h0, "R10");
    chk_irq(0, "R10");

    // R1 R2 rising edges, up count
    cur_req = "R1";
    wreg(3, 100);
    wreg(0, 16'h0003);
    repeat (5) pulse();
    chk(4, 5, "R1");

    // R2 falling edges
    cur_req = "R2";
    wreg(0, 16'h0002);
    wreg(4, 0);
    wreg(0, 16'h0007);
    repeat (4) pulse();
    chk(4, 4, "R2");

    // R9 write while enabled ignored, R2 both edges
    cur_req = "R9";
    wreg(0, 16'h000B);
    wreg(4, 16'h0050);
    chk(4, 4, "R9");
    repeat (3) pulse();
    chk(4, 10, "R2");

    // R6 up match wrap, R8 irq
    cur_req = "R6";
    wreg(0, 16'h0002);
    wreg(4, 0);
    chk(4, 0, "R9");
    wreg(3, 3);
    wreg(0, 16'h0013);
    repeat (4) pulse();
    chk(4, 1, "R6");
    chk(0, 16'h0013, "R6");
    chk_irq(1, "R8");

    // R7 clear flag
    cur_req = "R7";
    wreg(6, 1);
    chk(6, 0, "R7");
    chk_irq(0, "R7");

    // R4 down match with reload, R3 24-bit reload
    cur_req = "R4";
    wreg(0, 16'h0000);
    wreg(1, 5);
    wreg(2, 16'h0001);
    wreg(4, 8);
    wreg(5, 0);
    wreg(3, 5);
    wreg(0, 16'h0011);
    repeat (3) pulse();
    chk(4, 5, "R4");
    chk(5, 1, "R3");
    chk(0, 16'h0010, "R4");
    chk_irq(1, "R8");

    // R5 edges ignored while stopped
    cur_req = "R5";
    repeat (2) pulse();
    chk(4, 5, "R5");
    chk(5, 1, "R5");

    // re-enable continues from reload
    wreg(0, 16'h0011);
    pulse();
    chk(4, 4, "R4");

    // R8 mask off hides flag
    cur_req = "R8";
    wreg(0, 16'h0001);
    chk(6, 1, "R8");
    chk_irq(0, "R8");

    // R3 24-bit down wrap
    cur_req = "R3";
    wreg(0, 0);
    wreg(4, 0);
    wreg(5, 0);
    wreg(3, 16'h1234);
    wreg(0, 16'h0001);
    pulse();
    chk(4, 16'hFFFF, "R3");
    chk(5, 16'h00FF, "R3");

    repeat (4) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule